// File: doc/BRIEF.md
# Camera Shutter and Flash Pulse Timer

This block drives the shutter, pre-flash and main-flash pins of a camera module. It also drives the module's global-reset pin, whose direction can be set. Each of the three timed outputs is started by a frame trigger. The trigger is taken from one of three vertical-sync inputs or from the global-reset path. The chosen trigger is brought into the block through a two-flop synchronizer. Each rising edge then becomes a one-tick start event.

Each output channel is a small state machine with four states: CH_IDLE, CH_COUNT, CH_DELAY and CH_ACTIVE. It waits for a programmed number of frame events, then waits a programmed delay, then holds its pin high for a programmed length. The pre-flash channel can repeat its delay-and-pulse pair a programmed number of extra times. All timing counts are in ticks of a count enable. The divider produces that enable from the master clock at a ratio of N+1.

The global-reset generator has two states, GR_IDLE and GR_DRIVE. When the pin is an output, a start request makes it drive the pin for a programmed number of ticks. That driven pulse then acts as the frame trigger.

Channel transitions, all taken only on a tick:
- CH_IDLE to CH_COUNT: an event arrives with a frame count above 1.
- CH_IDLE or CH_COUNT to CH_DELAY or CH_ACTIVE: the last awaited event arrives. The channel goes to CH_ACTIVE directly when the delay is 0.
- CH_DELAY to CH_ACTIVE: the delay runs out.
- CH_ACTIVE back to CH_DELAY or CH_ACTIVE: the length runs out and a pre-flash repeat remains.
- CH_ACTIVE to CH_IDLE: the length runs out and no repeat remains.

Generator transitions:
- GR_IDLE to GR_DRIVE: a start request is pending on a tick and the programmed length is not zero.
- GR_DRIVE to GR_IDLE: the length runs out, or the direction bit is cleared.

Top module: `cam_pulse_timer`

## Requirements
- R1: A count tick occurs once every `div_ratio`+1 master cycles. Every channel pulse lasts exactly length × (`div_ratio`+1) cycles. Channel edges change only in the cycle after a tick.
- R2: `src_sel` 0 takes `vs_rx0`, 1 takes `vs_rx1`, 2 takes `vs_par`, and 3 takes the global-reset path. Edges on sources that are not selected start nothing.
- R3: With `src_sel`=3 and `grst_dir`=0, a rising edge of `grst_in` is the trigger. In this mode `grst_oe` is 0 and `grst_out` stays 0.
- R4: With `grst_dir`=1, `grst_oe` is 1. A `grst_start` pulse drives `grst_out` high for `grst_len` × (`div_ratio`+1) cycles. With `src_sel`=3, that driven pulse is the trigger and `grst_in` is ignored. `grst_out` is never high unless `grst_dir` was 1 in the previous cycle.
- R5: A trigger is taken on the rising edge of the selected source after a two-flop synchronizer. Say the source is first driven high just before clock edge C+1. With delay D, the channel output rises between cycle C+4+D×(N+1) and cycle C+4+N+D×(N+1).
- R6: Channel index 0 is the shutter, 1 the pre-flash and 2 the main flash. This index applies to `cfg_frames`, `cfg_delay` and `cfg_len`. Each channel rises D ticks after the F-th frame event it has counted, and stays high for L ticks.
- R7: A frame count of 0 keeps that channel idle; no pulse ever starts.
- R8: A length of 0 produces no pulse on that channel.
- R9: A trigger that arrives while a channel is in CH_DELAY or CH_ACTIVE is ignored and is not counted as a frame.
- R10: The pre-flash channel gives `pre_repeat`+1 pulses per start. Successive rising edges are (L+D) × (N+1) cycles apart. The other channels give one pulse.
- R11: A `grst_len` of 0 makes a start request produce no global-reset pulse and no trigger.
- R12: After reset all pulse outputs and `grst_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | Divider value N; one tick per N+1 cycles |
| src_sel | input | 2 | Trigger source select |
| grst_dir | input | 1 | Global-reset direction: 1 drives the pin |
| grst_start | input | 1 | Request for an internal global-reset pulse |
| vs_rx0 | input | 1 | Vertical sync, first serial receiver |
| vs_rx1 | input | 1 | Vertical sync, second serial receiver |
| vs_par | input | 1 | Vertical sync, parallel port |
| grst_in | input | 1 | Global-reset pin input |
| cfg_frames | input | 3×FRM_W | Frame count per channel |
| cfg_delay | input | 3×DLY_W | Delay in ticks per channel |
| cfg_len | input | 3×LEN_W | Pulse length in ticks per channel |
| pre_repeat | input | RPL_W | Extra pre-flash repeats |
| grst_len | input | LEN_W | Internal global-reset width in ticks |
| shutter_o | output | 1 | Shutter pulse |
| prestrobe_o | output | 1 | Pre-flash pulse |
| strobe_o | output | 1 | Main-flash pulse |
| grst_out | output | 1 | Global-reset pin drive value |
| grst_oe | output | 1 | Global-reset pin output enable |

## Verification
The bench uses the main-flash frame count of 2. A design that counted the first event as enough, or that never counted past one, would fire early or not at all. Triggers are sent while channels sit in their delay. A design that restarted there would emit a second pulse, which the monitor catches as unexpected. Repeated pre-flash pulses are checked for count and spacing, so an off-by-one repeat count shows up as a missing or extra pulse. Unselected sources, an external reset in drive mode and a zero frame, length or reset width must all stay silent. The internal reset pulse must be exactly the programmed width. A divider that is one cycle long or short would skew every width check.

// File: rtl/cam_pulse_pkg.sv
package cam_pulse_pkg;
    localparam int NUM_CH  = 3;
    localparam int CH_SHUT = 0;
    localparam int CH_PRE  = 1;
    localparam int CH_STRB = 2;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_COUNT  = 2'd1,
        CH_DELAY  = 2'd2,
        CH_ACTIVE = 2'd3
    } chan_state_e;

    typedef enum logic {
        GR_IDLE  = 1'b0,
        GR_DRIVE = 1'b1
    } grst_state_e;

    typedef enum logic [1:0] {
        SRC_RX0  = 2'd0,
        SRC_RX1  = 2'd1,
        SRC_PAR  = 2'd2,
        SRC_GRST = 2'd3
    } src_sel_e;
endpackage

// File: rtl/cpt_tick_div.sv
module cpt_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= ratio);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/cpt_trig_sel.sv
module cpt_trig_sel
    import cam_pulse_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] sel,
    input  logic       gr_dir,
    input  logic       vs_rx0,
    input  logic       vs_rx1,
    input  logic       vs_par,
    input  logic       grst_ext,
    input  logic       grst_int,
    output logic       evt
);
    logic raw;
    logic s1, s2, s3;
    logic pend;
    logic rise;

    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_RX0:  raw = vs_rx0;
            SRC_RX1:  raw = vs_rx1;
            SRC_PAR:  raw = vs_par;
            SRC_GRST: raw = gr_dir ? grst_int : grst_ext;
        endcase
    end

    assign rise = s2 & ~s3;
    assign evt  = pend & tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            pend <= 1'b0;
        end else begin
            s1   <= raw;
            s2   <= s1;
            s3   <= s2;
            pend <= rise | (pend & ~tick);
        end
    end
endmodule

// File: rtl/cpt_grst_gen.sv
module cpt_grst_gen
    import cam_pulse_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dir,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             drive
);
    grst_state_e      st, st_nx;
    logic [LEN_W-1:0] cnt, cnt_nx;
    logic             req, req_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= GR_IDLE;
            cnt <= '0;
            req <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            req <= req_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        req_nx = req;
        if (!dir) begin
            st_nx  = GR_IDLE;
            req_nx = 1'b0;
        end else begin
            unique case (st)
                GR_IDLE: begin
                    req_nx = req | start;
                    if (tick && req) begin
                        req_nx = start;
                        if (len != '0) begin
                            st_nx  = GR_DRIVE;
                            cnt_nx = len;
                        end
                    end
                end
                GR_DRIVE: begin
                    req_nx = 1'b0;
                    if (tick) begin
                        if (cnt == LEN_W'(1)) begin
                            st_nx = GR_IDLE;
                        end else begin
                            cnt_nx = cnt - LEN_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (st)
            GR_DRIVE: drive = 1'b1;
            default:  drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpt_pulse_chan.sv
module cpt_pulse_chan
    import cam_pulse_pkg::*;
#(
    parameter int FRM_W   = 4,
    parameter int DLY_W   = 12,
    parameter int LEN_W   = 12,
    parameter int RPL_W   = 4,
    parameter bit HAS_RPL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt,
    input  logic [FRM_W-1:0] frames,
    input  logic [DLY_W-1:0] delay,
    input  logic [LEN_W-1:0] len,
    input  logic [RPL_W-1:0] replay,
    output logic             pulse_o
);
    localparam int CNT_W = (DLY_W > LEN_W) ? DLY_W : LEN_W;

    chan_state_e      st, st_nx, launch_st;
    logic [CNT_W-1:0] cnt, cnt_nx, launch_cnt;
    logic [FRM_W-1:0] frm, frm_nx;
    logic [RPL_W-1:0] rpl, rpl_nx;

    assign launch_st  = (delay == '0) ? CH_ACTIVE : CH_DELAY;
    assign launch_cnt = (delay == '0) ? CNT_W'(len) : CNT_W'(delay);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
            frm <= '0;
            rpl <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            frm <= frm_nx;
            rpl <= rpl_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        frm_nx = frm;
        rpl_nx = rpl;
        if (tick) begin
            unique case (st)
                CH_IDLE: begin
                    if (evt && frames != '0 && len != '0) begin
                        rpl_nx = HAS_RPL ? replay : '0;
                        if (frames == FRM_W'(1)) begin
                            st_nx  = launch_st;
                            cnt_nx = launch_cnt;
                        end else begin
                            st_nx  = CH_COUNT;
                            frm_nx = frames - FRM_W'(1);
                        end
                    end
                end
                CH_COUNT: begin
                    if (evt) begin
                        if (frm == FRM_W'(1)) begin
                            st_nx  = launch_st;
                            cnt_nx = launch_cnt;
                        end else begin
                            frm_nx = frm - FRM_W'(1);
                        end
                    end
                end
                CH_DELAY: begin
                    if (cnt == CNT_W'(1)) begin
                        st_nx  = CH_ACTIVE;
                        cnt_nx = CNT_W'(len);
                    end else begin
                        cnt_nx = cnt - CNT_W'(1);
                    end
                end
                CH_ACTIVE: begin
                    if (cnt == CNT_W'(1)) begin
                        if (rpl != '0) begin
                            rpl_nx = rpl - RPL_W'(1);
                            st_nx  = launch_st;
                            cnt_nx = launch_cnt;
                        end else begin
                            st_nx = CH_IDLE;
                        end
                    end else begin
                        cnt_nx = cnt - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (st)
            CH_ACTIVE: pulse_o = 1'b1;
            default:   pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cam_pulse_timer.sv
module cam_pulse_timer
    import cam_pulse_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FRM_W = 4,
    parameter int DLY_W = 12,
    parameter int LEN_W = 12,
    parameter int RPL_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DIV_W-1:0]             div_ratio,
    input  logic [1:0]                   src_sel,
    input  logic                         grst_dir,
    input  logic                         grst_start,
    input  logic                         vs_rx0,
    input  logic                         vs_rx1,
    input  logic                         vs_par,
    input  logic                         grst_in,
    input  logic [NUM_CH-1:0][FRM_W-1:0] cfg_frames,
    input  logic [NUM_CH-1:0][DLY_W-1:0] cfg_delay,
    input  logic [NUM_CH-1:0][LEN_W-1:0] cfg_len,
    input  logic [RPL_W-1:0]             pre_repeat,
    input  logic [LEN_W-1:0]             grst_len,
    output logic                         shutter_o,
    output logic                         prestrobe_o,
    output logic                         strobe_o,
    output logic                         grst_out,
    output logic                         grst_oe
);
    logic              tick;
    logic              evt;
    logic              grst_drv;
    logic [NUM_CH-1:0] chan_pulse;

    cpt_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (div_ratio),
        .tick  (tick)
    );

    cpt_grst_gen #(.LEN_W(LEN_W)) u_grst (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .dir   (grst_dir),
        .start (grst_start),
        .len   (grst_len),
        .drive (grst_drv)
    );

    cpt_trig_sel u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sel      (src_sel),
        .gr_dir   (grst_dir),
        .vs_rx0   (vs_rx0),
        .vs_rx1   (vs_rx1),
        .vs_par   (vs_par),
        .grst_ext (grst_in),
        .grst_int (grst_drv),
        .evt      (evt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        cpt_pulse_chan #(
            .FRM_W   (FRM_W),
            .DLY_W   (DLY_W),
            .LEN_W   (LEN_W),
            .RPL_W   (RPL_W),
            .HAS_RPL (i == CH_PRE)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .evt     (evt),
            .frames  (cfg_frames[i]),
            .delay   (cfg_delay[i]),
            .len     (cfg_len[i]),
            .replay  (pre_repeat),
            .pulse_o (chan_pulse[i])
        );
    end

    assign shutter_o   = chan_pulse[CH_SHUT];
    assign prestrobe_o = chan_pulse[CH_PRE];
    assign strobe_o    = chan_pulse[CH_STRB];
    assign grst_out    = grst_drv;
    assign grst_oe     = grst_dir;
endmodule

// File: rtl/cam_pulse_timer_chk.sv
module cam_pulse_timer_chk
    import cam_pulse_pkg::*;
#(
    parameter int FRM_W = 4,
    parameter int LEN_W = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic                         grst_dir,
    input logic                         grst_out,
    input logic                         shutter_o,
    input logic                         prestrobe_o,
    input logic                         strobe_o,
    input logic [NUM_CH-1:0][FRM_W-1:0] cfg_frames,
    input logic [NUM_CH-1:0][LEN_W-1:0] cfg_len,
    input logic [LEN_W-1:0]             grst_len
);
    logic [NUM_CH-1:0] pulses;
    assign pulses = {strobe_o, prestrobe_o, shutter_o};

    a_r1_edges_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulses) |-> $past(tick));

    a_r4_drive_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        grst_out |-> $past(grst_dir));

    a_r11_zero_width_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grst_out) |-> $past(grst_len) != '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        a_r7_frames_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulses[i]) |-> $past(cfg_frames[i]) != '0);
        a_r8_len_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulses[i]) |-> $past(cfg_len[i]) != '0);
    end
endmodule

bind cam_pulse_timer cam_pulse_timer_chk #(.FRM_W(FRM_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .grst_dir    (grst_dir),
    .grst_out    (grst_out),
    .shutter_o   (shutter_o),
    .prestrobe_o (prestrobe_o),
    .strobe_o    (strobe_o),
    .cfg_frames  (cfg_frames),
    .cfg_len     (cfg_len),
    .grst_len    (grst_len)
);

// File: tb/test_cam_pulse_timer.sv
module test_cam_pulse_timer;
    localparam int DIV_W = 8, FRM_W = 4, DLY_W = 12, LEN_W = 12, RPL_W = 4;

    typedef struct {
        int lo;
        int hi;
        int width;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic [1:0] src_sel = '0;
    logic grst_dir = 1'b0, grst_start = 1'b0;
    logic vs_rx0 = 1'b0, vs_rx1 = 1'b0, vs_par = 1'b0, grst_in = 1'b0;
    logic [2:0][FRM_W-1:0] cfg_frames = '0;
    logic [2:0][DLY_W-1:0] cfg_delay = '0;
    logic [2:0][LEN_W-1:0] cfg_len = '0;
    logic [RPL_W-1:0] pre_repeat = '0;
    logic [LEN_W-1:0] grst_len = '0;
    logic shutter_o, prestrobe_o, strobe_o, grst_out, grst_oe;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int mcnt [3] = '{0, 0, 0};
    exp_t q0[$], q1[$], q2[$];

    cam_pulse_timer #(.DIV_W(DIV_W), .FRM_W(FRM_W), .DLY_W(DLY_W), .LEN_W(LEN_W), .RPL_W(RPL_W))
    i_cam_pulse_timer (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .src_sel(src_sel),
        .grst_dir(grst_dir), .grst_start(grst_start), .vs_rx0(vs_rx0), .vs_rx1(vs_rx1),
        .vs_par(vs_par), .grst_in(grst_in), .cfg_frames(cfg_frames), .cfg_delay(cfg_delay),
        .cfg_len(cfg_len), .pre_repeat(pre_repeat), .grst_len(grst_len),
        .shutter_o(shutter_o), .prestrobe_o(prestrobe_o), .strobe_o(strobe_o),
        .grst_out(grst_out), .grst_oe(grst_oe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    function automatic bit out_of(input int ch);
        case (ch)
            0: return shutter_o;
            1: return prestrobe_o;
            default: return strobe_o;
        endcase
    endfunction

    task automatic push_exp(input int ch, input exp_t e);
        case (ch)
            0: q0.push_back(e);
            1: q1.push_back(e);
            default: q2.push_back(e);
        endcase
    endtask

    task automatic pop_exp(input int ch, output exp_t e, output bit ok);
        ok = 1'b1;
        case (ch)
            0: if (q0.size() > 0) e = q0.pop_front(); else ok = 1'b0;
            1: if (q1.size() > 0) e = q1.pop_front(); else ok = 1'b0;
            default: if (q2.size() > 0) e = q2.pop_front(); else ok = 1'b0;
        endcase
    endtask

    // Model of R5, R6, R7, R8, R10: expected pulses from a trigger first seen high at edge C+1.
    task automatic trigger_at(input int c);
        int n = int'(div_ratio);
        for (int ch = 0; ch < 3; ch++) begin
            int f = int'(cfg_frames[ch]);
            int d = int'(cfg_delay[ch]);
            int l = int'(cfg_len[ch]);
            if (f != 0 && l != 0) begin
                mcnt[ch]++;
                if (mcnt[ch] == f) begin
                    int reps = (ch == 1) ? int'(pre_repeat) + 1 : 1;
                    mcnt[ch] = 0;
                    for (int j = 0; j < reps; j++) begin
                        exp_t e;
                        int base = c + d * (n + 1) + j * (l + d) * (n + 1);
                        e.lo = base + 4;
                        e.hi = base + 4 + n;
                        e.width = l * (n + 1);
                        push_exp(ch, e);
                    end
                end
            end
        end
    endtask

    task automatic mon(input int ch);
        forever begin
            @(negedge clk);
            if (rst_n && out_of(ch)) begin
                int r = cyc;
                int w = 0;
                exp_t e;
                bit ok;
                while (out_of(ch)) begin
                    w++;
                    @(negedge clk);
                end
                pop_exp(ch, e, ok);
                if (!ok) begin
                    chk(1'b0, "R2/R7/R8/R9", $sformatf("unexpected pulse ch%0d", ch), r, -1);
                end else begin
                    chk(r >= e.lo && r <= e.hi, "R5/R6/R10", $sformatf("rise cycle ch%0d", ch), r, e.lo);
                    chk(w == e.width, "R1/R6", $sformatf("pulse width ch%0d", ch), w, e.width);
                end
            end
        end
    endtask

    // which: 0 vs_rx0, 1 vs_rx1, 2 vs_par, 3 grst_in
    task automatic pulse_src(input int which, input bit honor);
        int c;
        @(negedge clk);
        case (which)
            0: vs_rx0 = 1'b1;
            1: vs_rx1 = 1'b1;
            2: vs_par = 1'b1;
            default: grst_in = 1'b1;
        endcase
        c = cyc;
        if (honor && int'(src_sel) == which && (which != 3 || !grst_dir)) trigger_at(c);
        repeat (3) @(negedge clk);
        vs_rx0 = 1'b0; vs_rx1 = 1'b0; vs_par = 1'b0; grst_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_chan(input int ch, input int f, input int d, input int l);
        @(negedge clk);
        cfg_frames[ch] = FRM_W'(f);
        cfg_delay[ch]  = DLY_W'(d);
        cfg_len[ch]    = LEN_W'(l);
    endtask

    task automatic grst_kick();
        int g = -1;
        int w = 0;
        int n = int'(div_ratio);
        @(negedge clk);
        grst_start = 1'b1;
        @(negedge clk);
        grst_start = 1'b0;
        for (int k = 0; k < 40 && g < 0; k++) begin
            if (grst_out) g = cyc;
            else @(negedge clk);
        end
        if (grst_len == '0) begin
            chk(g < 0, "R11", "zero-width reset pulse appeared", g, -1);
        end else begin
            chk(g >= 0, "R4", "internal reset pulse missing", g, 0);
            if (g >= 0) begin
                if (src_sel == 2'd3) trigger_at(g);
                while (grst_out) begin
                    w++;
                    @(negedge clk);
                end
                chk(w == int'(grst_len) * (n + 1), "R4", "internal reset width", w, int'(grst_len) * (n + 1));
            end
        end
    endtask

    initial begin
        fork
            mon(0);
            mon(1);
            mon(2);
        join_none
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk({shutter_o, prestrobe_o, strobe_o, grst_out} == 4'b0, "R12", "outputs after reset",
            int'({shutter_o, prestrobe_o, strobe_o, grst_out}), 0);

        // R6 R10: base sequence, source 0, divider 1:1, strobe waits two frames
        set_chan(0, 1, 3, 4);
        set_chan(1, 1, 2, 2);
        set_chan(2, 2, 1, 3);
        pre_repeat = 4'd2;
        pulse_src(0, 1'b1);
        idle(80);
        pulse_src(0, 1'b1);
        idle(80);

        // R2: unselected sources and grst_in while src_sel=0
        pulse_src(1, 1'b1);
        pulse_src(2, 1'b1);
        pulse_src(3, 1'b1);
        idle(60);

        // R1 R2: divider 3, source 1
        div_ratio = 8'd2;
        src_sel = 2'd1;
        set_chan(2, 1, 2, 2);
        pulse_src(1, 1'b1);
        idle(150);
        pulse_src(0, 1'b1);
        idle(60);
        src_sel = 2'd2;
        pulse_src(2, 1'b1);
        idle(150);

        // R7 R8: frame count 0 on shutter, length 0 on strobe
        div_ratio = 8'd1;
        set_chan(0, 0, 2, 3);
        set_chan(2, 1, 2, 0);
        pulse_src(2, 1'b1);
        idle(120);

        // R9: retrigger during delay is ignored
        div_ratio = 8'd0;
        pre_repeat = 4'd0;
        set_chan(0, 1, 20, 5);
        set_chan(1, 1, 20, 5);
        set_chan(2, 1, 20, 5);
        pulse_src(2, 1'b1);
        idle(6);
        pulse_src(2, 1'b0);
        idle(80);

        // R3: external global reset as trigger
        set_chan(0, 1, 2, 3);
        set_chan(1, 1, 1, 2);
        set_chan(2, 1, 3, 1);
        src_sel = 2'd3;
        grst_dir = 1'b0;
        @(negedge clk);
        chk(grst_oe == 1'b0, "R3", "grst_oe in input mode", int'(grst_oe), 0);
        pulse_src(3, 1'b1);
        chk(grst_out == 1'b0, "R3", "grst_out in input mode", int'(grst_out), 0);
        idle(60);

        // R4: internal global reset drives the pin and triggers
        div_ratio = 8'd1;
        grst_len = 12'd4;
        grst_dir = 1'b1;
        @(negedge clk);
        chk(grst_oe == 1'b1, "R4", "grst_oe in drive mode", int'(grst_oe), 1);
        grst_kick();
        idle(80);
        pulse_src(3, 1'b1);
        idle(60);

        // R11: zero width request
        grst_len = '0;
        grst_kick();
        idle(60);

        chk(q0.size() == 0, "R6", "shutter pulses missing", q0.size(), 0);
        chk(q1.size() == 0, "R10", "prestrobe pulses missing", q1.size(), 0);
        chk(q2.size() == 0, "R6", "strobe pulses missing", q2.size(), 0);
        finish_run();
    end
endmodule